// File: doc/BRIEF.md
# Periodic Interrupt Timer with Add-on-Return

This block produces a steady interrupt rate for software that needs regular service, such as a bit-banged serial link or a tone generator. It has an 8-bit up-counter. A power-of-two prescaler driven by the system clock advances it. When the counter steps from 0xFF to 0x00 and both the run bit and the interrupt-enable bit are set, a pending flag goes high. While the flag and both enables are set, the interrupt request is asserted.

No compare or reload register sets the period. The interrupt handler is entered with the count just past zero, and the count keeps advancing while the handler runs. At return the core pulses an add strobe with an 8-bit operand, and that operand is added to the live count. The operand and the prescale setting together fix the time to the next wrap.

Software reaches the block through a byte-wide write port. A strobe writes the count and a second strobe writes the control word. Both values can always be read back. To dismiss an interrupt, software first drops an enable, then writes 0 to the flag bit. A flag that is still set when the enables come back raises the request again.

Top module: `pitTimer`

## Requirements
- R1: After reset the count, the control word and the prescaler are all zero, and `irqOut` is low.
- R2: The control word has the run bit at bit 0, the interrupt-enable bit at bit 1, the pending flag at bit 2 (read back as the flag), bit 3 reading 0, and the prescale select N at bits 7:4. A write to `wrCtrl` loads bits 0, 1 and 7:4 from `wrData`.
- R3: While running, the count advances by one every 2^N clock cycles for N from 0 to 8.
- R4: Select values above 8 divide by 256, the same as N = 8.
- R5: The prescaler is held at zero while the run bit is low. The count does not advance while the run bit is low, and the first advance after enabling comes a full 2^N cycles later.
- R6: The pending flag sets only when an increment takes the count from 0xFF to 0x00 while both the run bit and the interrupt-enable bit are 1.
- R7: `irqOut` is high exactly when the pending flag, the run bit and the interrupt-enable bit are all 1.
- R8: Writing 0 to bit 2 of the control word clears the flag. Writing 1 to that bit, or clearing an enable, leaves the flag set, and the request returns when the enables are restored.
- R9: When the flag sets and is cleared in the same cycle, the set wins.
- R10: An `addStrobe` adds `addOperand` to the count modulo 256. If a prescaler increment falls in the same cycle, the result is count + operand + 1.
- R11: A wrap caused by the add alone does not set the pending flag.
- R12: A `wrCount` write loads `wrData` into the count and overrides both the increment and the add in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrCount | input | 1 | Write strobe for the count register |
| wrCtrl | input | 1 | Write strobe for the control word |
| wrData | input | 8 | Write data for either register |
| addStrobe | input | 1 | Return-with-add pulse from the core |
| addOperand | input | 8 | Value added to the count on `addStrobe` |
| countOut | output | 8 | Current count |
| ctrlOut | output | 8 | Control and status word |
| irqOut | output | 1 | Interrupt request |

## Verification
The counter is driven with prescale selects of 0, 2 and 15. These runs separate the per-cycle rate, a plain power-of-two divide and the clamp at 256. A disable made partway through a prescale period shows whether the prescaler restarts from zero. Wraps are produced with the interrupt enable on and with it off, and with a flag clear landing in the same cycle as a wrap. These cases separate the flag's enable gating from the priority of set over clear. The add path is tried with and without a coinciding increment, with an add that wraps by itself, and against a simultaneous count write. These cases tell the +1 merge, the rule that an add-only wrap leaves the flag alone, and the write priority apart from one another.

// File: rtl/pitPkg.sv
package pitPkg;
  // control word bit positions (software visible)
  localparam int RUN_BIT  = 0;
  localparam int IEN_BIT  = 1;
  localparam int FLAG_BIT = 2;
  localparam int SEL_LSB  = 4;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic tick;  // prescaler period complete, count steps by one
    logic load;  // software write of the count
    logic add;   // return-with-add
  } dpStrobes_t;
endpackage

// File: rtl/pitPrescaler.sv
module pitPrescaler #(
  parameter int PS_W  = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(PS_W);

  logic [PS_W-1:0]  psCount;
  logic [SEL_W-1:0] clampSel;
  logic [PS_W-1:0]  bitDone;

  assign clampSel = (sel > MAX_SEL) ? MAX_SEL : sel;

  // a bit at or above the selected width does not take part in the period
  for (genvar i = 0; i < PS_W; i++) begin : g_bitDone
    assign bitDone[i] = psCount[i] | (i >= int'(clampSel));
  end

  assign tick = enable & (&bitDone);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) psCount <= '0;
    else                  psCount <= psCount + 1'b1;
  end

  // R5: prescaler sits at zero after any cycle with the run bit low
  a_r5_ps_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> psCount == '0);
endmodule

// File: rtl/pitControl.sv
module pitControl
  import pitPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtrl,
  input  logic              wrCount,
  input  logic              addStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic              incWrap,
  output dpStrobes_t        strobes,
  output logic              runEn,
  output logic [SEL_W-1:0]  psSel,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              irq
);
  logic intEn;
  logic pending;
  logic setFlag;
  logic clrFlag;

  assign strobes.tick = tick;
  assign strobes.load = wrCount;
  assign strobes.add  = addStrobe;

  assign setFlag = incWrap & runEn & intEn;
  assign clrFlag = wrCtrl & ~wrData[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn <= 1'b0;
      intEn <= 1'b0;
      psSel <= '0;
    end else if (wrCtrl) begin
      runEn <= wrData[RUN_BIT];
      intEn <= wrData[IEN_BIT];
      psSel <= wrData[SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        pending <= 1'b0;
    else if (setFlag) pending <= 1'b1;   // set beats clear
    else if (clrFlag) pending <= 1'b0;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[RUN_BIT]  = runEn;
    ctrlWord[IEN_BIT]  = intEn;
    ctrlWord[FLAG_BIT] = pending;
    ctrlWord[SEL_LSB +: SEL_W] = psSel;
  end

  assign irq = pending & runEn & intEn;

  // R6, R11: a new flag needs an increment wrap with both enables
  a_r6_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(incWrap && runEn && intEn));
  // R8: flag holds unless a zero is written to it
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    pending && !(wrCtrl && !wrData[FLAG_BIT]) |=> pending);
  // R9: wrap with enables always leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    incWrap && runEn && intEn |=> pending);
endmodule

// File: rtl/pitDatapath.sv
module pitDatapath
  import pitPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] addOperand,
  output logic [DATA_W-1:0] count,
  output logic              incWrap
);
  logic [DATA_W-1:0] stepVal;
  logic [DATA_W-1:0] addVal;
  logic [DATA_W-1:0] nextCount;

  assign stepVal = strobes.tick ? DATA_W'(1) : '0;
  assign addVal  = strobes.add ? addOperand : '0;

  // only the increment step can report a wrap; a load cancels it
  assign incWrap = strobes.tick & ~strobes.load & (count == '1);

  always_comb begin
    if (strobes.load) nextCount = wrData;
    else              nextCount = count + addVal + stepVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= nextCount;
  end

  // R12: software write wins over step and add
  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> count == $past(wrData));
  // R10: add without a step lands exactly on count + operand
  a_r10_add_only: assert property (@(posedge clk) disable iff (!rstN)
    strobes.add && !strobes.load && !strobes.tick
      |=> count == DATA_W'($past(count) + $past(addOperand)));
  // R5: with no strobe at all the count is stable
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.add && !strobes.load && !strobes.tick |=> $stable(count));
endmodule

// File: rtl/pitTimer.sv
module pitTimer
  import pitPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PS_W   = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCount,
  input  logic              wrCtrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              addStrobe,
  input  logic [DATA_W-1:0] addOperand,
  output logic [DATA_W-1:0] countOut,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              irqOut
);
  dpStrobes_t       strobes;
  logic             tick;
  logic             incWrap;
  logic             runEn;
  logic [SEL_W-1:0] psSel;

  pitPrescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
    .clk(clk), .rstN(rstN), .enable(runEn), .sel(psSel), .tick(tick)
  );

  pitControl #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrCount(wrCount),
    .addStrobe(addStrobe), .wrData(wrData), .tick(tick), .incWrap(incWrap),
    .strobes(strobes), .runEn(runEn), .psSel(psSel), .ctrlWord(ctrlOut),
    .irq(irqOut)
  );

  pitDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .addOperand(addOperand), .count(countOut), .incWrap(incWrap)
  );

  // R7: request is never raised without the flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ctrlOut[FLAG_BIT]);
endmodule

// File: tb/tb_pitTimer.sv
module tb_pitTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrCount = 1'b0;
  logic       wrCtrl = 1'b0;
  logic [7:0] wrData = '0;
  logic       addStrobe = 1'b0;
  logic [7:0] addOperand = '0;
  logic [7:0] countOut;
  logic [7:0] ctrlOut;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pitTimer dut (
    .clk(clk), .rstN(rstN), .wrCount(wrCount), .wrCtrl(wrCtrl),
    .wrData(wrData), .addStrobe(addStrobe), .addOperand(addOperand),
    .countOut(countOut), .ctrlOut(ctrlOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // every helper starts and ends at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putCtrl(input logic [7:0] v);
    wrCtrl = 1'b1; wrData = v;
    @(negedge clk);
    wrCtrl = 1'b0;
  endtask

  task automatic putCount(input logic [7:0] v);
    wrCount = 1'b1; wrData = v;
    @(negedge clk);
    wrCount = 1'b0;
  endtask

  task automatic pulseAdd(input logic [7:0] v);
    addStrobe = 1'b1; addOperand = v;
    @(negedge clk);
    addStrobe = 1'b0;
  endtask

  task automatic testReset();
    check("R1 count", countOut, 8'h00);
    check("R1 ctrl", ctrlOut, 8'h00);
    check("R1 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testRateFull();
    putCtrl(8'h01);
    idle(10);
    check("R3 N=0 count", countOut, 8'd10);
    check("R2 ctrl readback", ctrlOut, 8'h01);
  endtask

  task automatic testRateDiv4();
    putCtrl(8'h00);
    putCount(8'h00);
    putCtrl(8'h21);
    idle(11);
    check("R3 N=2 before step", countOut, 8'd2);
    idle(1);
    check("R3 N=2 on step", countOut, 8'd3);
  endtask

  task automatic testClamp();
    putCtrl(8'h00);
    putCount(8'h00);
    putCtrl(8'hF1);
    idle(255);
    check("R4 sel15 before step", countOut, 8'd0);
    idle(1);
    check("R4 sel15 on step", countOut, 8'd1);
  endtask

  task automatic testPsRestart();
    putCtrl(8'h00);
    putCount(8'h00);
    putCtrl(8'h21);
    idle(2);
    putCtrl(8'h20);
    idle(1);
    check("R5 halted count", countOut, 8'd0);
    putCtrl(8'h21);
    idle(3);
    check("R5 no early step", countOut, 8'd0);
    idle(1);
    check("R5 full period step", countOut, 8'd1);
  endtask

  task automatic testWrapFlag();
    putCtrl(8'h00);
    putCount(8'hFE);
    putCtrl(8'h03);
    idle(1);
    check("R6 before wrap flag", ctrlOut, 8'h03);
    idle(1);
    check("R6 wrap count", countOut, 8'h00);
    check("R6 flag set", ctrlOut, 8'h07);
    check("R7 irq on wrap", {7'b0, irqOut}, 8'h01);
  endtask

  task automatic testClearSeq();
    putCtrl(8'h85);
    check("R8 flag kept after ien off", ctrlOut, 8'h85);
    check("R7 irq off with ien 0", {7'b0, irqOut}, 8'h00);
    putCtrl(8'h87);
    check("R8 request returns", {7'b0, irqOut}, 8'h01);
    putCtrl(8'h81);
    check("R8 flag cleared", ctrlOut, 8'h81);
    check("R7 irq low after clear", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testNoIen();
    putCtrl(8'h00);
    putCount(8'hFF);
    putCtrl(8'h01);
    idle(1);
    check("R6 wrap count no ien", countOut, 8'h00);
    check("R6 no flag without ien", ctrlOut, 8'h01);
    check("R7 no irq without ien", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testSetWins();
    putCtrl(8'h00);
    putCount(8'hFE);
    putCtrl(8'h03);
    idle(1);
    putCtrl(8'h03);  // clear lands on the wrap cycle
    check("R9 set beats clear", ctrlOut, 8'h07);
  endtask

  task automatic testAddStep();
    putCtrl(8'h01);
    putCount(8'h10);
    pulseAdd(8'h20);
    check("R10 add with step", countOut, 8'h31);
  endtask

  task automatic testAddWrap();
    putCtrl(8'h00);
    putCount(8'hF0);
    putCtrl(8'h83);
    pulseAdd(8'h20);
    check("R10 add modulo", countOut, 8'h10);
    check("R11 add wrap no flag", ctrlOut, 8'h83);
  endtask

  task automatic testLoadWins();
    putCtrl(8'h01);
    wrCount = 1'b1; wrData = 8'h77; addStrobe = 1'b1; addOperand = 8'h05;
    @(negedge clk);
    wrCount = 1'b0; addStrobe = 1'b0;
    check("R12 write beats add and step", countOut, 8'h77);
  endtask

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    testReset();
    testRateFull();
    testRateDiv4();
    testClamp();
    testPsRestart();
    testWrapFlag();
    testClearSeq();
    testNoIen();
    testSetWins();
    testAddStep();
    testAddWrap();
    testLoadWins();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule